// File: doc/BRIEF.md
# System Control Register File

This block is a memory-mapped control and identification register file on a simple 32-bit register bus. Its window spans 1024 word slots (4 KiB of byte space), but storage exists only for the low 512 words. Requests use a valid/ready handshake and carry a word index, a write flag and write data. A read returns its data one cycle after acceptance, marked by a read-valid strobe. Any access to a slot without storage returns an access-error pulse in the same response cycle.

Four identification words come out of reset with fixed non-zero values. Three of them, along with no other word, read back with two status bits forced high. The stored contents do not change. One slot above the storage, at word 0x3C0 (byte offset 0xF00), acts as a command port. Writing a restart code there raises a one-cycle system-reset request. Writing the power-off code raises a one-cycle system-shutdown request. The block only raises these pulses. Acting on them is left to logic outside the block.

The bus side is a two-state machine. In `ST_IDLE` the block is ready. On an accepted request (transition *accept*) it moves to `ST_RESP`, where it presents the response and any pulses with ready low. It returns unconditionally to `ST_IDLE` on the next cycle (transition *retire*). A new request can therefore be accepted every second cycle.

Top module: `sysctl_regfile`

## Requirements
- R1: After reset, word 0x40 holds 0x05F20121, word 0x41 holds 0x00000002, word 0x42 holds 0x05F30121 and word 0x43 holds 0x05F40121. Every other backed word holds zero. `req_ready` is high and all response outputs are low.
- R2: A write to a backed word (index below 0x200) stores the data. An accepted read drives `rd_valid` high for exactly the following cycle, with `rd_data` holding the word.
- R3: A read of word 0x40, 0x42 or 0x43 returns the stored value with bits 29 and 28 set (OR with 0x30000000), and the stored value is left unchanged. No other word is altered on read.
- R4: A read of word index 0x200 or above returns zero, with `acc_err` high in the response cycle.
- R5: A write to word index 0x200 or above stores nothing, and no backed word changes. `acc_err` is high in the cycle after acceptance.
- R6: A write to word 0x3C0 with data 1 or 2 raises `sys_reset_req` for the single cycle after acceptance.
- R7: A write to word 0x3C0 with data 3 raises `sys_shutdown_req` for the single cycle after acceptance.
- R8: A write to word 0x3C0 with any other data, or a command code written to any other index, raises neither request.
- R9: `req_ready` is low in the cycle after an acceptance, so accepted requests are at least two cycles apart.
- R10: The reset and shutdown requests are never high together, with reset winning any conflict. Each lasts one cycle.
- R11: `acc_err` lasts only the one response cycle of the offending access and is not sticky.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_idx | input | IDX_W (10) | Word index in the window (byte offset / 4) |
| req_wdata | input | DATA_W (32) | Write data |
| rd_valid | output | 1 | Read response strobe |
| rd_data | output | DATA_W (32) | Read response data |
| acc_err | output | 1 | Access outside backed storage, one-cycle pulse |
| sys_reset_req | output | 1 | System-reset request pulse |
| sys_shutdown_req | output | 1 | System-shutdown request pulse |

## Verification
Some properties are checked by assertions on every cycle:
- an accepted read always yields a read strobe one cycle later;
- ready is low whenever a response is presented;
- unbacked read data is zero;
- the error and request pulses last one cycle and never overlap;
- each request pulse traces back to an accepted command write carrying the matching code;
- a forced word always reads with its two status bits high.

Other behaviour only the bench scenarios can show, because it depends on what was stored earlier:
- the reset contents;
- the unchanged stored value behind a forced word;
- the absence of aliasing when an unbacked write lands on an index whose low bits match a backed word;
- the silence of the command port for codes other than 1, 2 and 3.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } bus_state_e;

    typedef enum logic [1:0] {
        CMD_NONE     = 2'd0,
        CMD_RESET    = 2'd1,
        CMD_SHUTDOWN = 2'd2
    } cmd_kind_e;

    localparam logic [31:0] STATUS_FORCE = 32'h3000_0000;

    function automatic logic [31:0] word_reset_value(input int unsigned idx);
        logic [31:0] v;
        case (idx)
            32'h40:  v = 32'h05F2_0121;
            32'h41:  v = 32'h0000_0002;
            32'h42:  v = 32'h05F3_0121;
            32'h43:  v = 32'h05F4_0121;
            default: v = 32'h0;
        endcase
        return v;
    endfunction

    function automatic logic is_forced_word(input int unsigned idx);
        return (idx == 32'h40) || (idx == 32'h42) || (idx == 32'h43);
    endfunction

endpackage

// File: rtl/sysctl_store.sv
module sysctl_store
    import sysctl_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 10,
    parameter int DEPTH  = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_hit,
    output logic [DATA_W-1:0] rd_word
);
    localparam int SAW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [IDX_W:0] DEPTH_L = (IDX_W+1)'(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic              wr_hit;

    generate
        if (DEPTH >= (1 << IDX_W)) begin : g_full
            assign wr_hit = 1'b1;
            assign rd_hit = 1'b1;
        end else begin : g_partial
            assign wr_hit = ({1'b0, wr_idx} < DEPTH_L);
            assign rd_hit = ({1'b0, rd_idx} < DEPTH_L);
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= DATA_W'(word_reset_value(i));
            end
        end else if (wr_en && wr_hit) begin
            mem[wr_idx[SAW-1:0]] <= wr_data;
        end
    end

    assign rd_word = rd_hit ? mem[rd_idx[SAW-1:0]] : '0;

endmodule

// File: rtl/sysctl_cmd.sv
module sysctl_cmd
    import sysctl_pkg::*;
#(
    parameter int          DATA_W  = 32,
    parameter int          IDX_W   = 10,
    parameter logic [31:0] CMD_IDX = 32'h3C0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_we,
    input  logic [IDX_W-1:0]  cmd_idx,
    input  logic [DATA_W-1:0] cmd_data,
    output logic              sys_reset_req,
    output logic              sys_shutdown_req
);
    localparam logic [IDX_W-1:0]  CMD_SLOT  = IDX_W'(CMD_IDX);
    localparam logic [DATA_W-1:0] CODE_RST0 = DATA_W'(1);
    localparam logic [DATA_W-1:0] CODE_RST1 = DATA_W'(2);
    localparam logic [DATA_W-1:0] CODE_OFF  = DATA_W'(3);

    cmd_kind_e kind;

    always_comb begin
        kind = CMD_NONE;
        if (cmd_we && (cmd_idx == CMD_SLOT)) begin
            if ((cmd_data == CODE_RST0) || (cmd_data == CODE_RST1)) begin
                kind = CMD_RESET;
            end else if (cmd_data == CODE_OFF) begin
                kind = CMD_SHUTDOWN;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sys_reset_req    <= 1'b0;
            sys_shutdown_req <= 1'b0;
        end else begin
            unique case (kind)
                CMD_RESET: begin
                    sys_reset_req    <= 1'b1;
                    sys_shutdown_req <= 1'b0;
                end
                CMD_SHUTDOWN: begin
                    sys_reset_req    <= 1'b0;
                    sys_shutdown_req <= 1'b1;
                end
                default: begin
                    sys_reset_req    <= 1'b0;
                    sys_shutdown_req <= 1'b0;
                end
            endcase
        end
    end

    AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(sys_reset_req && sys_shutdown_req));  // R10
    AST_RESET_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        sys_reset_req |-> $past(cmd_we && cmd_idx == CMD_SLOT
                                && (cmd_data == CODE_RST0 || cmd_data == CODE_RST1)));  // R6
    AST_SHUTDOWN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        sys_shutdown_req |-> $past(cmd_we && cmd_idx == CMD_SLOT && cmd_data == CODE_OFF));  // R7
    AST_RESET_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        sys_reset_req |=> !sys_reset_req);  // R10

endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
    import sysctl_pkg::*;
#(
    parameter int          DATA_W       = 32,
    parameter int          IDX_W        = 10,
    parameter int          BACKED_WORDS = 512,
    parameter logic [31:0] CMD_IDX      = 32'h3C0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [IDX_W-1:0]  req_idx,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              acc_err,
    output logic              sys_reset_req,
    output logic              sys_shutdown_req
);
    localparam logic [DATA_W-1:0] FORCE_MASK = DATA_W'(STATUS_FORCE);
    localparam logic [IDX_W-1:0]  PROBE_IDX  = IDX_W'(32'h40);

    bus_state_e        state_q, state_d;
    logic              accept;
    logic              backed;
    logic [DATA_W-1:0] store_word;
    logic [DATA_W-1:0] force_bits;

    assign req_ready  = (state_q == ST_IDLE);
    assign accept     = req_valid && req_ready;
    assign force_bits = is_forced_word(32'(req_idx)) ? FORCE_MASK : '0;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_RESP;
            ST_RESP: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
            acc_err  <= 1'b0;
        end else begin
            rd_valid <= accept && !req_write;
            acc_err  <= accept && !backed;
            if (accept && !req_write) begin
                rd_data <= backed ? (store_word | force_bits) : '0;
            end else begin
                rd_data <= '0;
            end
        end
    end

    sysctl_store #(
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W),
        .DEPTH  (BACKED_WORDS)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (accept && req_write),
        .wr_idx  (req_idx),
        .wr_data (req_wdata),
        .rd_idx  (req_idx),
        .rd_hit  (backed),
        .rd_word (store_word)
    );

    sysctl_cmd #(
        .DATA_W  (DATA_W),
        .IDX_W   (IDX_W),
        .CMD_IDX (CMD_IDX)
    ) u_cmd (
        .clk              (clk),
        .rst_n            (rst_n),
        .cmd_we           (accept && req_write),
        .cmd_idx          (req_idx),
        .cmd_data         (req_wdata),
        .sys_reset_req    (sys_reset_req),
        .sys_shutdown_req (sys_shutdown_req)
    );

    AST_READ_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_write) |=> rd_valid);  // R2
    AST_RDVALID_CAUSED: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(req_valid && req_ready && !req_write));  // R2
    AST_UNBACKED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && acc_err) |-> (rd_data == '0));  // R4
    AST_BUSY_IN_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid || acc_err || sys_reset_req || sys_shutdown_req) |-> !req_ready);  // R9
    AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err |=> !acc_err);  // R11
    AST_FORCED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_write && req_idx == PROBE_IDX)
        |=> (rd_data[29] && rd_data[28]));  // R3

endmodule

// File: tb/sim_sysctl_regfile.sv
`timescale 1ns/1ps
module sim_sysctl_regfile;

    typedef struct {
        logic        is_rd;
        logic [31:0] data;
        logic        err;
        logic        rst;
        logic        shut;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [9:0]  req_idx = '0;
    logic [31:0] req_wdata = '0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic        acc_err;
    logic        sys_reset_req;
    logic        sys_shutdown_req;

    int   total = 0;
    int   bad = 0;
    bit   started = 1'b0;
    bit   finished = 1'b0;
    bit   exp_now = 1'b0;
    bit   post_chk = 1'b0;
    exp_t q[$];

    always #2.5 clk = ~clk;

    sysctl_regfile u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_idx(req_idx), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .acc_err(acc_err),
        .sys_reset_req(sys_reset_req), .sys_shutdown_req(sys_shutdown_req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic [9:0] idx, input logic [31:0] d,
                          input logic [31:0] exp_d, input logic e, input logic r,
                          input logic s, input string tag);
        exp_t it;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        it.is_rd = !wr; it.data = exp_d; it.err = e; it.rst = r; it.shut = s; it.tag = tag;
        q.push_back(it);
        req_valid = 1'b1; req_write = wr; req_idx = idx; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input logic [9:0] idx, input logic [31:0] exp_d, input logic e, input string tag);
        access(1'b0, idx, 32'h0, exp_d, e, 1'b0, 1'b0, tag);
    endtask

    task automatic wr(input logic [9:0] idx, input logic [31:0] d, input logic e,
                      input logic r, input logic s, input string tag);
        access(1'b1, idx, d, 32'h0, e, r, s, tag);
    endtask

    // monitor: compares each response cycle against the queued expectation
    always @(negedge clk) begin
        #1;
        if (started) begin
            if (exp_now) begin
                if (q.size() == 0) begin
                    bad++;
                    $display("FAIL R2 act=response exp=queued item");
                end else begin
                    exp_t it;
                    it = q.pop_front();
                    chk({it.tag, " rd_valid"}, {31'b0, rd_valid}, {31'b0, it.is_rd});
                    if (it.is_rd) chk({it.tag, " rd_data"}, rd_data, it.data);
                    chk({it.tag, " acc_err"}, {31'b0, acc_err}, {31'b0, it.err});
                    chk({it.tag, " sys_reset_req"}, {31'b0, sys_reset_req}, {31'b0, it.rst});
                    chk({it.tag, " sys_shutdown_req"}, {31'b0, sys_shutdown_req}, {31'b0, it.shut});
                    chk("R9 ready low in response", {31'b0, req_ready}, 32'h0);
                end
                post_chk = 1'b1;
            end else begin
                if (post_chk) begin
                    chk("R10 R11 pulses ended", {28'b0, rd_valid, acc_err, sys_reset_req, sys_shutdown_req}, 32'h0);
                end else if (rd_valid || acc_err || sys_reset_req || sys_shutdown_req) begin
                    chk("R10 R11 no spurious pulse", {28'b0, rd_valid, acc_err, sys_reset_req, sys_shutdown_req}, 32'h0);
                end
                post_chk = 1'b0;
            end
            exp_now = req_valid && req_ready;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            bad++;
            total++;
            $display("FAIL watchdog act=hung exp=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready after reset", {31'b0, req_ready}, 32'h1);
        chk("R1 outputs idle", {28'b0, rd_valid, acc_err, sys_reset_req, sys_shutdown_req}, 32'h0);
        chk("R1 rd_data zero", rd_data, 32'h0);
        started = 1'b1;

        // R1 reset contents (0x40/0x42/0x43 also forced per R3)
        rd(10'h040, 32'h35F2_0121, 1'b0, "R1 word40");
        rd(10'h041, 32'h0000_0002, 1'b0, "R1 word41");
        rd(10'h042, 32'h35F3_0121, 1'b0, "R1 word42");
        rd(10'h043, 32'h35F4_0121, 1'b0, "R1 word43");
        rd(10'h000, 32'h0, 1'b0, "R1 word0");
        rd(10'h1FF, 32'h0, 1'b0, "R1 word1ff");

        // R2 store and read back
        wr(10'h005, 32'hA5A5_1234, 1'b0, 1'b0, 1'b0, "R2 write5");
        rd(10'h005, 32'hA5A5_1234, 1'b0, "R2 read5");
        wr(10'h1FF, 32'h0BAD_F00D, 1'b0, 1'b0, 1'b0, "R2 write1ff");
        rd(10'h1FF, 32'h0BAD_F00D, 1'b0, "R2 read1ff");

        // R3 forced bits, stored value untouched
        wr(10'h040, 32'h0, 1'b0, 1'b0, 1'b0, "R3 clear40");
        rd(10'h040, 32'h3000_0000, 1'b0, "R3 read40");
        wr(10'h041, 32'h0, 1'b0, 1'b0, 1'b0, "R3 clear41");
        rd(10'h041, 32'h0, 1'b0, "R3 read41 unforced");
        wr(10'h044, 32'h12, 1'b0, 1'b0, 1'b0, "R3 write44");
        rd(10'h044, 32'h12, 1'b0, "R3 read44 unforced");
        wr(10'h043, 32'h0000_00FF, 1'b0, 1'b0, 1'b0, "R3 write43");
        rd(10'h043, 32'h3000_00FF, 1'b0, "R3 read43");
        rd(10'h043, 32'h3000_00FF, 1'b0, "R3 reread43 stable");

        // R4 unbacked reads
        rd(10'h200, 32'h0, 1'b1, "R4 read200");
        rd(10'h3FF, 32'h0, 1'b1, "R4 read3ff");

        // R5 unbacked write, no aliasing onto word 0 / word 5
        wr(10'h200, 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0, "R5 write200");
        rd(10'h000, 32'h0, 1'b0, "R5 word0 unchanged");
        wr(10'h205, 32'h1111_1111, 1'b1, 1'b0, 1'b0, "R5 write205");
        rd(10'h005, 32'hA5A5_1234, 1'b0, "R5 word5 unchanged");

        // R6 R7 R8 command port
        wr(10'h3C0, 32'h1, 1'b1, 1'b1, 1'b0, "R6 cmd1");
        wr(10'h3C0, 32'h2, 1'b1, 1'b1, 1'b0, "R6 cmd2");
        wr(10'h3C0, 32'h3, 1'b1, 1'b0, 1'b1, "R7 cmd3");
        wr(10'h3C0, 32'h0, 1'b1, 1'b0, 1'b0, "R8 cmd0");
        wr(10'h3C0, 32'h4, 1'b1, 1'b0, 1'b0, "R8 cmd4");
        wr(10'h3C0, 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0, "R8 cmdffffffff");
        wr(10'h3C1, 32'h1, 1'b1, 1'b0, 1'b0, "R8 code at 3c1");
        wr(10'h0F0, 32'h1, 1'b0, 1'b0, 1'b0, "R8 code at backed f0");
        rd(10'h0F0, 32'h1, 1'b0, "R8 f0 stored");
        rd(10'h3C0, 32'h0, 1'b1, "R4 read cmd slot");

        // R11 error is not sticky: a clean access right after an error
        rd(10'h300, 32'h0, 1'b1, "R11 err read");
        rd(10'h042, 32'h35F3_0121, 1'b0, "R11 clean after err");

        while (q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule